// File: doc/BRIEF.md
# SDRAM Read-Truncation Command Scheduler

This block sits on the controller side of an SDRAM interface. It takes a stream of read, write and precharge requests and issues at most one memory command per clock. For each command it picks the earliest cycle that still delivers exactly the number of data elements the previous request asked for. A read burst is ended by the next READ or by a same-bank PRECHARGE placed CAS latency minus one cycles before the last wanted element. A WRITE that follows a read waits until the data mask has been held high long enough to silence the rest of the read burst. The mask is driven low again on the write cycle itself.

Requests are presented on a valid/ready pair. `req_ready` stays low until the timing rule for the request at the head is met. The CAS latency (2 or 3) and an optional one-cycle bus turnaround bubble are static configuration inputs. Row activation, refresh and pad timing belong to other blocks. Command and mask outputs are registered, so an accepted request appears on the command port in the following cycle.

Top module: `sdram_rd_trunc_sched`

## Requirements
- R1: After reset `cmd_op` is 0 (no operation) and `cmd_dqm` is low.
- R2: Command codes are 0 none, 1 READ, 2 WRITE, 3 PRECHARGE, and `req_op` uses the same codes. Each accepted request issues one command in the next cycle, carrying its bank, column and auto-precharge flag. Every other cycle shows code 0.
- R3: A READ after a READ or WRITE of length L, and a WRITE after a WRITE of length L, appear exactly L cycles after that command. With L = 1 a READ can issue on every cycle.
- R4: A PRECHARGE to the same bank as a preceding READ or WRITE of length L appears L cycles after it. A PRECHARGE to another bank appears one cycle after it. Any command issues one cycle after a PRECHARGE.
- R5: A PRECHARGE request to the bank of an immediately preceding READ that had auto-precharge set is accepted and discarded. No command is issued for it, and the spacing of the next command is unchanged.
- R6: A WRITE after a READ of length L appears CL+L+1 cycles after the READ, where CL is 3 when `cfg_cl3` is high and 2 otherwise. When `cfg_bubble` is high it appears one cycle later.
- R7: For a WRITE that follows a READ issued at cycle T, `cmd_dqm` is high from cycle T+CL+L-2 through the cycle before the WRITE, which makes at least three cycles. It is low on the WRITE cycle.
- R8: `cmd_dqm` is low whenever the most recent command is not a READ, and in particular during read-only and write-only sequences.
- R9: While the head request is not yet allowed, `req_ready` is low and the request is held. For a READ of length L followed at once by another READ, the second one waits L-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | CAS latency select: 1 gives 3, 0 gives 2 |
| cfg_bubble | input | 1 | Adds one idle cycle before a WRITE that follows a READ |
| req_valid | input | 1 | Head request present |
| req_ready | output | 1 | Head request is taken this cycle |
| req_op | input | 2 | Request kind (1 read, 2 write, 3 precharge) |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Number of wanted data elements (at least 1) |
| req_autopre | input | 1 | Auto-precharge flag for a read or write |
| cmd_op | output | 2 | Issued command code |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| cmd_autopre | output | 1 | Auto-precharge flag of the issued command |
| cmd_dqm | output | 1 | Data mask toward the memory |

## Verification
The mask ramp and the write decision share a cycle boundary. On the last cycle before the WRITE, the mask must still be high while the WRITE is being chosen, and on the next cycle the mask must drop exactly as the WRITE appears. The bench provokes this by queuing a WRITE directly behind a READ, with CL 2 and no bubble and again with CL 3 and the bubble on. It logs the mask on every bus cycle and compares it against the window computed from the READ's cycle, CL and length. A discarded PRECHARGE landing in the cycle where the following READ becomes eligible is also checked: the READ must keep the spacing it would have without the PRECHARGE.

// File: rtl/rdtrunc_pkg.sv
package rdtrunc_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_PRE   = 2'd3
    } op_e;

endpackage

// File: rtl/rdtrunc_gap_calc.sv
module rdtrunc_gap_calc
    import rdtrunc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int LEN_W  = 4,
    parameter int SW     = LEN_W + 3
) (
    input  op_e               last_op,
    input  logic [LEN_W-1:0]  last_len,
    input  logic [BANK_W-1:0] last_bank,
    input  logic              last_ap,
    input  logic [SW-1:0]     since,
    input  logic              cl3,
    input  logic              bubble,
    input  op_e               head_op,
    input  logic [BANK_W-1:0] head_bank,
    input  logic              mask_ok,
    output logic              may_issue,
    output logic              drop
);
    localparam logic [SW-1:0] ONE = SW'(1);

    logic [SW-1:0] cl_x, len_x, wr_gap, need;
    logic          same_bank, need_mask;

    always_comb begin
        cl_x      = cl3 ? SW'(3) : SW'(2);
        len_x     = SW'(last_len);
        wr_gap    = cl_x + len_x + ONE + SW'(bubble);
        same_bank = (last_bank == head_bank);
        need      = ONE;
        need_mask = 1'b0;
        unique case (last_op)
            OP_READ: begin
                unique case (head_op)
                    OP_WRITE: begin
                        need      = wr_gap;
                        need_mask = 1'b1;
                    end
                    OP_PRE:  need = same_bank ? len_x : ONE;
                    default: need = len_x;
                endcase
            end
            OP_WRITE: begin
                if (head_op == OP_PRE) need = same_bank ? len_x : ONE;
                else                   need = len_x;
            end
            default: need = ONE;
        endcase
        drop = (head_op == OP_NOP) ||
               (head_op == OP_PRE && last_op == OP_READ && last_ap && same_bank);
        may_issue = !drop && (since >= need) && (!need_mask || mask_ok);
    end
endmodule

// File: rtl/rdtrunc_mask_ctl.sv
module rdtrunc_mask_ctl #(
    parameter int LEN_W = 4,
    parameter int SW    = LEN_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_is_read,
    input  logic [LEN_W-1:0] last_len,
    input  logic [SW-1:0]    since,
    input  logic             cl3,
    input  logic             head_write,
    input  logic             write_fire,
    output logic             dqm,
    output logic             mask_ok
);
    localparam logic [1:0] RUN_FULL = 2'd3;

    typedef struct packed {
        logic       dqm;
        logic [1:0] run;
    } mstate_t;

    mstate_t m_q, m_d;
    logic [SW-1:0] mask_start;

    always_comb begin
        mask_start = (cl3 ? SW'(3) : SW'(2)) + SW'(last_len) - SW'(2);
        m_d        = m_q;
        m_d.dqm    = last_is_read && (since >= mask_start) && head_write && !write_fire;
        if (!m_d.dqm)              m_d.run = 2'd0;
        else if (m_q.run != RUN_FULL) m_d.run = m_q.run + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign dqm     = m_q.dqm;
    assign mask_ok = (m_q.run == RUN_FULL);

    assert_mask_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.dqm |-> last_is_read);

    assert_mask_not_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_q.dqm) |-> (since > mask_start));
endmodule

// File: rtl/sdram_rd_trunc_sched.sv
module sdram_rd_trunc_sched
    import rdtrunc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cl3,
    input  logic              cfg_bubble,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_autopre,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              cmd_dqm
);
    localparam int            SW        = LEN_W + 3;
    localparam logic [SW-1:0] SINCE_MAX = '1;

    typedef struct packed {
        op_e               cmd_op;
        logic [BANK_W-1:0] cmd_bank;
        logic [COL_W-1:0]  cmd_col;
        logic              cmd_ap;
        op_e               last_op;
        logic [LEN_W-1:0]  last_len;
        logic [BANK_W-1:0] last_bank;
        logic              last_ap;
        logic [SW-1:0]     since;
    } state_t;

    state_t s_q, s_d;
    op_e    head_op;
    logic   may_issue, drop, mask_ok, issue, write_fire;

    assign head_op = op_e'(req_op);

    rdtrunc_gap_calc #(.BANK_W(BANK_W), .LEN_W(LEN_W), .SW(SW)) u_gap (
        .last_op   (s_q.last_op),
        .last_len  (s_q.last_len),
        .last_bank (s_q.last_bank),
        .last_ap   (s_q.last_ap),
        .since     (s_q.since),
        .cl3       (cfg_cl3),
        .bubble    (cfg_bubble),
        .head_op   (head_op),
        .head_bank (req_bank),
        .mask_ok   (mask_ok),
        .may_issue (may_issue),
        .drop      (drop)
    );

    assign req_ready  = may_issue | drop;
    assign issue      = req_valid & may_issue;
    assign write_fire = issue & (head_op == OP_WRITE);

    rdtrunc_mask_ctl #(.LEN_W(LEN_W), .SW(SW)) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .last_is_read (s_q.last_op == OP_READ),
        .last_len     (s_q.last_len),
        .since        (s_q.since),
        .cl3          (cfg_cl3),
        .head_write   (req_valid && head_op == OP_WRITE),
        .write_fire   (write_fire),
        .dqm          (cmd_dqm),
        .mask_ok      (mask_ok)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cmd_op = OP_NOP;
        if (s_q.since != SINCE_MAX) s_d.since = s_q.since + SW'(1);
        if (issue) begin
            s_d.cmd_op    = head_op;
            s_d.cmd_bank  = req_bank;
            s_d.cmd_col   = req_col;
            s_d.cmd_ap    = req_autopre;
            s_d.last_op   = head_op;
            s_d.last_len  = req_len;
            s_d.last_bank = req_bank;
            s_d.last_ap   = req_autopre;
            s_d.since     = SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cmd_op  <= OP_NOP;
            s_q.last_op <= OP_NOP;
            s_q.since   <= SINCE_MAX;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_op      = s_q.cmd_op;
    assign cmd_bank    = s_q.cmd_bank;
    assign cmd_col     = s_q.cmd_col;
    assign cmd_autopre = s_q.cmd_ap;

    assert_cmd_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 2'd0) |-> $past(req_valid && req_ready));

    assert_read_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && head_op == OP_READ &&
         (s_q.last_op == OP_READ || s_q.last_op == OP_WRITE))
        |-> (s_q.since >= SW'(s_q.last_len)));

    assert_autopre_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && head_op == OP_PRE && s_q.last_op == OP_READ && s_q.last_ap &&
         req_bank == s_q.last_bank) |=> (cmd_op == 2'd0));

    assert_mask_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd2 && $past(s_q.last_op) == OP_READ)
        |-> (!cmd_dqm && $past(cmd_dqm) && $past(cmd_dqm, 2) && $past(cmd_dqm, 3)));
endmodule

// File: tb/sim_sdram_rd_trunc_sched.sv
`timescale 1ns/1ps
module sim_sdram_rd_trunc_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cl3 = 1'b0, cfg_bubble = 1'b0;
    logic       req_valid = 1'b0, req_autopre = 1'b0;
    logic [1:0] req_op = 2'd0, req_bank = 2'd0;
    logic [7:0] req_col = 8'd0;
    logic [3:0] req_len = 4'd1;
    logic       req_ready, cmd_autopre, cmd_dqm;
    logic [1:0] cmd_op, cmd_bank;
    logic [7:0] cmd_col;

    sdram_rd_trunc_sched u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, tick = 0, base = 0;
    bit logging = 0, done = 0;
    int lop[64], lbank[64], lcol[64], lap[64], ldq[64];

    always @(posedge clk) tick <= tick + 1;

    always @(negedge clk) begin
        if (logging && (tick - base) >= 0 && (tick - base) < 64) begin
            lop[tick-base]   = cmd_op;
            lbank[tick-base] = cmd_bank;
            lcol[tick-base]  = cmd_col;
            lap[tick-base]   = cmd_autopre;
            ldq[tick-base]   = cmd_dqm;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_log();
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            lop[i] = 0; lbank[i] = 0; lcol[i] = 0; lap[i] = 0; ldq[i] = 0;
        end
        base = tick;
        logging = 1;
    endtask

    task automatic end_log();
        repeat (14) @(negedge clk);
        logging = 0;
    endtask

    function automatic int nth_cmd(input int n);
        int k = 0;
        for (int i = 0; i < 64; i++) begin
            if (lop[i] != 0) begin
                if (k == n) return i;
                k++;
            end
        end
        return -1;
    endfunction

    task automatic send(input int op, input int bank, input int col, input int len,
                        input int ap, output int stalls);
        bit rdy;
        req_valid = 1; req_op = 2'(op); req_bank = 2'(bank);
        req_col = 8'(col); req_len = 4'(len); req_autopre = ap[0];
        stalls = 0;
        rdy = 0;
        while (!rdy) begin
            #1;
            rdy = req_ready;
            @(negedge clk);
            if (!rdy) stalls++;
        end
        req_valid = 0;
    endtask

    task automatic mask_window(input string req, input int t0, input int lo, input int hi,
                               input int span);
        int bad = 0;
        for (int i = t0; i <= t0 + span && i < 64; i++)
            if (ldq[i] != ((i >= lo && i <= hi) ? 1 : 0)) bad++;
        check(req, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 cmd_op after reset", cmd_op, 0);
        check("R1 dqm after reset", cmd_dqm, 0);
    endtask

    task automatic t_read_chain();
        int st, t0, t1, t2, t3, hi;
        cfg_cl3 = 0; cfg_bubble = 0;
        start_log();
        send(1, 0, 10, 4, 0, st);
        send(1, 0, 14, 1, 0, st);
        check("R9 stall cycles behind len 4 read", st, 3);
        send(1, 2, 15, 1, 0, st);
        send(1, 0, 16, 2, 0, st);
        end_log();
        t0 = nth_cmd(0); t1 = nth_cmd(1); t2 = nth_cmd(2); t3 = nth_cmd(3);
        check("R2 first op is READ", (t0 >= 0) ? lop[t0] : -1, 1);
        check("R2 first bank", (t0 >= 0) ? lbank[t0] : -1, 0);
        check("R2 first column", (t0 >= 0) ? lcol[t0] : -1, 10);
        check("R3 read gap after len 4", t1 - t0, 4);
        check("R3 read gap after len 1", t2 - t1, 1);
        check("R3 read gap after len 1 other bank", t3 - t2, 1);
        check("R2 bank of third read", (t2 >= 0) ? lbank[t2] : -1, 2);
        hi = 0;
        for (int i = 0; i < 64; i++) hi += ldq[i];
        check("R8 mask during reads only", hi, 0);
    endtask

    task automatic t_write_after_read(input bit cl3, input bit bub, input int len,
                                      input int wlen, input string tag);
        int st, tr, tw, cl;
        cfg_cl3 = cl3; cfg_bubble = bub;
        cl = cl3 ? 3 : 2;
        start_log();
        send(1, 1, 30, len, 0, st);
        send(2, 1, 20, wlen, 0, st);
        end_log();
        tr = nth_cmd(0); tw = nth_cmd(1);
        check({"R6 write gap ", tag}, tw - tr, cl + len + 1 + (bub ? 1 : 0));
        check({"R2 write op ", tag}, (tw >= 0) ? lop[tw] : -1, 2);
        check({"R2 write column ", tag}, (tw >= 0) ? lcol[tw] : -1, 20);
        mask_window({"R7 mask window ", tag}, tr, tr + cl + len - 2, tr + cl + len + (bub ? 1 : 0), cl + len + 4);
        check({"R7 mask low on write ", tag}, (tw >= 0) ? ldq[tw] : -1, 0);
    endtask

    task automatic t_write_chain();
        int st, t0, t1, t2, hi;
        cfg_cl3 = 0; cfg_bubble = 0;
        start_log();
        send(2, 0, 40, 3, 0, st);
        send(1, 0, 50, 2, 0, st);
        send(3, 0, 0, 1, 0, st);
        end_log();
        t0 = nth_cmd(0); t1 = nth_cmd(1); t2 = nth_cmd(2);
        check("R3 read after len 3 write", t1 - t0, 3);
        check("R4 precharge after len 2 read same bank", t2 - t1, 2);
        hi = 0;
        for (int i = 0; i < 64; i++) hi += ldq[i];
        check("R8 mask with no write behind a read", hi, 0);
    endtask

    task automatic t_precharge();
        int st, t0, t1, t2, t3;
        cfg_cl3 = 1; cfg_bubble = 0;
        start_log();
        send(1, 2, 60, 4, 0, st);
        send(3, 2, 0, 1, 0, st);
        send(1, 0, 70, 4, 0, st);
        send(3, 3, 0, 1, 0, st);
        end_log();
        t0 = nth_cmd(0); t1 = nth_cmd(1); t2 = nth_cmd(2); t3 = nth_cmd(3);
        check("R4 precharge same bank gap", t1 - t0, 4);
        check("R2 precharge op code", (t1 >= 0) ? lop[t1] : -1, 3);
        check("R4 read after precharge gap", t2 - t1, 1);
        check("R4 precharge other bank gap", t3 - t2, 1);
    endtask

    task automatic t_autopre();
        int st, t0, t1;
        cfg_cl3 = 0; cfg_bubble = 0;
        start_log();
        send(1, 1, 80, 2, 1, st);
        send(3, 1, 0, 1, 0, st);
        send(1, 1, 90, 1, 0, st);
        end_log();
        t0 = nth_cmd(0); t1 = nth_cmd(1);
        check("R2 autopre flag carried", (t0 >= 0) ? lap[t0] : -1, 1);
        check("R5 next op after dropped precharge", (t1 >= 0) ? lop[t1] : -1, 1);
        check("R5 spacing unchanged", t1 - t0, 2);
        check("R5 no extra command", nth_cmd(2), -1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_read_chain();
        t_write_after_read(1'b0, 1'b0, 3, 2, "cl2");
        t_write_after_read(1'b1, 1'b1, 2, 1, "cl3 bubble");
        t_write_chain();
        t_precharge();
        t_autopre();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule